// File: doc/BRIEF.md
# Instruction Prefix and Opcode Front-End Parser

This block takes instruction bytes one per cycle over a valid/ready handshake and splits the start of each instruction into its parts. It first collects any leading override bytes. Each override byte is sorted into one of three groups: segment selection, operand width and address width. The block notes when the same group shows up more than once. It then takes a primary opcode of one byte, or of two bytes when an escape byte comes first. If the opcode calls for it, the block also takes the addressing-form byte that follows and splits it into its three fields.

A small lookup table decides whether an opcode needs an addressing byte. It holds one bit per opcode value for each of the two opcode spaces, one-byte and escaped. A write port loads the table, normally once after reset.

When an instruction is complete, the block shows the full record for exactly one cycle. It accepts no byte during that cycle. After that it is ready for the first byte of the next instruction.

Top module: `insn_prefix_parser`

## Requirements
- R1: A segment override byte sets `seg_valid` and reports a 3-bit code: 26h→0, 2Eh→1, 36h→2, 3Eh→3, 64h→4, 65h→5. With no segment byte, `seg_valid` is 0 and the code is 0.
- R2: Byte 66h sets `opsize_ovr` and byte 67h sets `adsize_ovr`. The override bytes of different groups are taken in any order.
- R3: A second byte from the same group sets `redundant` but does not reject the instruction. For segment bytes, the last one seen sets the code. One byte from each of several groups leaves `redundant` at 0.
- R4: Byte 0Fh in the prefix/opcode position is an escape. The next byte is the opcode, and `two_byte` is 1. Otherwise `two_byte` is 0 and the first byte that is not an override is the opcode.
- R5: The table bit at address {two_byte, opcode} (9 bits, escape flag in bit 8) selects whether an addressing byte follows. When it is 1, the next byte is split into mod = bits 7:6, reg = bits 5:3 and rm = bits 2:0, and `has_modrm` is 1.
- R6: When the table bit is 0, the record completes right after the opcode byte, with `has_modrm` = 0 and mod, reg and rm all 0.
- R7: `out_valid` is high for exactly one cycle, the cycle after the final byte of the instruction is accepted. `in_ready` is low in that cycle. The next instruction starts with all flags cleared.
- R8: While `in_valid` is low, the parser holds its state. Idle gaps between bytes do not change the record or its timing relative to the last accepted byte.
- R9: A synchronous reset drops a partly parsed instruction and clears all flags. After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte is present |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Parser accepts a byte this cycle |
| tbl_we | input | 1 | Lookup table write enable |
| tbl_addr | input | 9 | Table address {escape, opcode} |
| tbl_data | input | 1 | 1 = opcode needs an addressing byte |
| out_valid | output | 1 | One-cycle record strobe |
| seg_valid | output | 1 | A segment override was seen |
| seg_code | output | 3 | Segment override code |
| opsize_ovr | output | 1 | Operand-size override seen |
| adsize_ovr | output | 1 | Address-size override seen |
| redundant | output | 1 | A group repeated |
| two_byte | output | 1 | Opcode came after the escape byte |
| opcode | output | 8 | Final opcode byte |
| has_modrm | output | 1 | Addressing byte captured |
| mod_f | output | 2 | mod field |
| reg_f | output | 3 | reg/opcode field |
| rm_f | output | 3 | r/m field |

## Verification
The bench sends two segment bytes in a row and checks that the second code wins and `redundant` rises. A design that kept the first code, or that discarded the instruction, would fail this test.

It also looks up one opcode value in both opcode spaces with different table bits. A design that ignored the escape flag in the lookup would then take or skip the addressing byte at the wrong time and shift the next instruction. Idle gaps and a reset in the middle of an instruction show whether the flags stay in place or leak into the next record. A byte offered during the strobe cycle shows whether a design swallows the first byte of the next instruction.

// File: rtl/insn_prefix_parser.sv
module insn_prefix_parser #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  input  logic              tbl_we,
  input  logic [BYTE_W:0]   tbl_addr,
  input  logic              tbl_data,
  output logic              out_valid,
  output logic              seg_valid,
  output logic [2:0]        seg_code,
  output logic              opsize_ovr,
  output logic              adsize_ovr,
  output logic              redundant,
  output logic              two_byte,
  output logic [BYTE_W-1:0] opcode,
  output logic              has_modrm,
  output logic [1:0]        mod_f,
  output logic [2:0]        reg_f,
  output logic [2:0]        rm_f
);
  localparam int TBL_N = 2 << BYTE_W;

  typedef enum logic [1:0] {S_PFX, S_OPC2, S_MODRM, S_DONE} state_t;
  state_t state;

  logic [TBL_N-1:0] need_tbl;
  logic             hs, is_seg, need;
  logic [2:0]       seg_dec;

  assign in_ready  = (state != S_DONE);
  assign out_valid = (state == S_DONE);
  assign hs        = in_valid && in_ready;
  assign need      = need_tbl[{state == S_OPC2, in_byte}];

  always_comb begin
    is_seg  = 1'b1;
    seg_dec = 3'd0;
    case (in_byte)
      8'h26:   seg_dec = 3'd0;
      8'h2E:   seg_dec = 3'd1;
      8'h36:   seg_dec = 3'd2;
      8'h3E:   seg_dec = 3'd3;
      8'h64:   seg_dec = 3'd4;
      8'h65:   seg_dec = 3'd5;
      default: is_seg = 1'b0;
    endcase
  end

  always_ff @(posedge clk)
    if (tbl_we) need_tbl[tbl_addr] <= tbl_data;

  always_ff @(posedge clk) begin
    if (rst || state == S_DONE) begin
      state      <= S_PFX;
      seg_valid  <= 1'b0;
      seg_code   <= 3'd0;
      opsize_ovr <= 1'b0;
      adsize_ovr <= 1'b0;
      redundant  <= 1'b0;
      two_byte   <= 1'b0;
      opcode     <= '0;
      has_modrm  <= 1'b0;
      mod_f      <= 2'd0;
      reg_f      <= 3'd0;
      rm_f       <= 3'd0;
    end else if (hs) begin
      case (state)
        S_PFX: begin
          if (is_seg) begin
            seg_valid <= 1'b1;
            seg_code  <= seg_dec;
            if (seg_valid) redundant <= 1'b1;
          end else if (in_byte == 8'h66) begin
            opsize_ovr <= 1'b1;
            if (opsize_ovr) redundant <= 1'b1;
          end else if (in_byte == 8'h67) begin
            adsize_ovr <= 1'b1;
            if (adsize_ovr) redundant <= 1'b1;
          end else if (in_byte == 8'h0F) begin
            two_byte <= 1'b1;
            state    <= S_OPC2;
          end else begin
            opcode    <= in_byte;
            has_modrm <= need;
            state     <= need ? S_MODRM : S_DONE;
          end
        end
        S_OPC2: begin
          opcode    <= in_byte;
          has_modrm <= need;
          state     <= need ? S_MODRM : S_DONE;
        end
        S_MODRM: begin
          mod_f <= in_byte[7:6];
          reg_f <= in_byte[5:3];
          rm_f  <= in_byte[2:0];
          state <= S_DONE;
        end
        default: state <= S_PFX;
      endcase
    end
  end

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  a_r7_no_accept_in_done: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && state != S_DONE) |=> $stable({state, seg_code, opsize_ovr, adsize_ovr, redundant}));
  a_r3_repeat_flagged: assert property (@(posedge clk) disable iff (rst)
    (hs && state == S_PFX && is_seg && seg_valid) |=> redundant);
  a_r4_escape_step: assert property (@(posedge clk) disable iff (rst)
    (hs && state == S_PFX && in_byte == 8'h0F) |=> (state == S_OPC2 && two_byte));
  a_r6_no_modrm_done: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !has_modrm) |-> (mod_f == 2'd0 && reg_f == 3'd0 && rm_f == 3'd0));
endmodule

// File: tb/insn_prefix_parser_bench.sv
module insn_prefix_parser_bench;
  logic clk = 0, rst = 1, in_valid = 0, tbl_we = 0, tbl_data = 0;
  logic [7:0] in_byte = 0;
  logic [8:0] tbl_addr = 0;
  logic in_ready, out_valid, seg_valid, opsize_ovr, adsize_ovr, redundant, two_byte, has_modrm;
  logic [2:0] seg_code, reg_f, rm_f;
  logic [1:0] mod_f;
  logic [7:0] opcode;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  insn_prefix_parser u_insn_prefix_parser (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b, int gap = 0);
    for (int i = 0; i < gap; i++) @(negedge clk);
    @(negedge clk);
    in_valid = 1; in_byte = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic wait_rec();
    int n = 0;
    @(negedge clk);
    while (!out_valid && n < 20) begin @(negedge clk); n++; end
    chk("R7 record strobe", out_valid, 1);
    chk("R7 ready low during strobe", in_ready, 0);
  endtask

  task automatic rec(string req, int sv, int sc, int op, int ad, int rd, int tb,
                     int opc, int hm, int md, int rg, int r);
    chk({req, " seg_valid"}, seg_valid, sv);
    chk({req, " seg_code"}, seg_code, sc);
    chk({req, " opsize"}, opsize_ovr, op);
    chk({req, " adsize"}, adsize_ovr, ad);
    chk({req, " redundant"}, redundant, rd);
    chk({req, " two_byte"}, two_byte, tb);
    chk({req, " opcode"}, opcode, opc);
    chk({req, " has_modrm"}, has_modrm, hm);
    chk({req, " mod"}, mod_f, md);
    chk({req, " reg"}, reg_f, rg);
    chk({req, " rm"}, rm_f, r);
  endtask

  task automatic wr_tbl(int a, bit d);
    @(negedge clk); tbl_we = 1; tbl_addr = a[8:0]; tbl_data = d;
    @(negedge clk); tbl_we = 0;
  endtask

  task automatic t_reset_state();
    chk("R9 reset out_valid", out_valid, 0);
    chk("R9 reset in_ready", in_ready, 1);
  endtask

  task automatic t_plain_no_modrm();
    send(8'h90); wait_rec();
    rec("R6 R4 plain", 0, 0, 0, 0, 0, 0, 8'h90, 0, 0, 0, 0);
    @(negedge clk);
    chk("R7 strobe one cycle", out_valid, 0);
  endtask

  task automatic t_segments();
    logic [7:0] b[6] = '{8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65};
    for (int i = 0; i < 6; i++) begin
      send(b[i]); send(8'hC3); wait_rec();
      rec("R1 segment", 1, i, 0, 0, 0, 0, 8'hC3, 0, 0, 0, 0);
    end
  endtask

  task automatic t_mixed_order();
    send(8'h67); send(8'h3E); send(8'h66); send(8'h89); send(8'hD8); wait_rec();
    rec("R2 R5 mixed", 1, 3, 1, 1, 0, 0, 8'h89, 1, 3, 3, 0);
    send(8'h66); send(8'h8B); send(8'h45); wait_rec();
    rec("R2 R7 fresh opsize", 0, 0, 1, 0, 0, 0, 8'h8B, 1, 1, 0, 5);
  endtask

  task automatic t_repeats();
    send(8'h2E); send(8'h65); send(8'h90); wait_rec();
    rec("R3 last segment wins", 1, 5, 0, 0, 1, 0, 8'h90, 0, 0, 0, 0);
    send(8'h66); send(8'h66); send(8'h90); wait_rec();
    rec("R3 repeated opsize", 0, 0, 1, 0, 1, 0, 8'h90, 0, 0, 0, 0);
    send(8'h67); send(8'h67); send(8'h90); wait_rec();
    rec("R3 repeated adsize", 0, 0, 0, 1, 1, 0, 8'h90, 0, 0, 0, 0);
  endtask

  task automatic t_escape();
    send(8'h0F); send(8'hAF); send(8'hC1); wait_rec();
    rec("R4 R5 escaped modrm", 0, 0, 0, 0, 0, 1, 8'hAF, 1, 3, 0, 1);
    send(8'h0F); send(8'h89); wait_rec();
    rec("R5 escape space lookup", 0, 0, 0, 0, 0, 1, 8'h89, 0, 0, 0, 0);
    send(8'h66); send(8'h0F); send(8'hA2); wait_rec();
    rec("R4 escaped no modrm", 0, 0, 1, 0, 0, 1, 8'hA2, 0, 0, 0, 0);
  endtask

  task automatic t_gaps();
    send(8'h26, 3); send(8'h0F, 4); send(8'hAF, 2);
    repeat (3) @(negedge clk);
    chk("R8 no strobe while idle", out_valid, 0);
    send(8'h7A, 1); wait_rec();
    rec("R8 gaps", 1, 0, 0, 0, 0, 1, 8'hAF, 1, 1, 7, 2);
  endtask

  task automatic t_mid_reset();
    send(8'h66); send(8'h2E);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    chk("R9 in_ready after reset", in_ready, 1);
    send(8'h90); wait_rec();
    rec("R9 flags cleared", 0, 0, 0, 0, 0, 0, 8'h90, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset_state();
    wr_tbl(9'h089, 1); wr_tbl(9'h08B, 1); wr_tbl(9'h1AF, 1);
    wr_tbl(9'h090, 0); wr_tbl(9'h0C3, 0); wr_tbl(9'h189, 0); wr_tbl(9'h1A2, 0);
    t_plain_no_modrm();
    t_segments();
    t_mixed_order();
    t_repeats();
    t_escape();
    t_gaps();
    t_mid_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule